// File: doc/BRIEF.md
# Integer Adder with Carry and Status Flags

This block executes the integer add family of a 32-bit fixed-point datapath. It decodes the primary and extended opcode fields of an instruction itself. It chooses the operands: register contents, a zero constant, a sign-extended immediate, a shifted immediate or an all-ones constant. It then forms a single sum with an optional carry-in.

Alongside the sum it keeps the architectural arithmetic status. This is a carry flag, an overflow flag and a sticky summary-overflow flag, plus a 4-bit comparison field that describes the sign of the result.

Register read and write happen outside the block. The caller presents the source register index and contents with `in_valid_i`. One cycle later the block returns the result with a write enable, a write enable for the comparison field, and the updated flag values. The sticky flag can be cleared only by reset or by the `sum_ovf_clr_i` input.

Top module: `int_add_unit`

## Requirements
- R1: With primary opcode 31, the 9-bit extended opcode selects the form. 266 is plain add, 10 is add with carry-out, 138 is add with carry-in, 234 is add plus carry minus one and 202 is add plus carry. The first two return src_a + src_b.
- R2: Primary opcode 14 is add immediate and 15 is add shifted immediate; neither changes the carry flag. Primary opcode 12 is add immediate with carry-out. Primary opcode 13 is add immediate with carry-out and a comparison update.
- R3: Carry-in forms compute src_a + src_b + carry, src_a + carry + 0xFFFFFFFF, and src_a + carry, using the carry flag held before the instruction.
- R4: For opcodes 14 and 15, a source index of 0 makes the first operand the constant 0. For opcodes 12 and 13, index 0 still uses the register contents.
- R5: Opcode 15 adds the 16-bit immediate placed in the upper half with zeros below it. Opcodes 12, 13 and 14 add the immediate sign-extended to 32 bits.
- R6: For opcode-31 forms with the overflow-enable bit at 1, the overflow flag takes the signed overflow of the sum, and the sticky flag is set when that overflow is 1. With the bit at 0, both flags keep their values.
- R7: For opcode-31 forms with the record bit at 1, `cmp_we_o` pulses and `cmp_o` takes the result's signed comparison with zero. The encoding is cmp_o[3]=negative, cmp_o[2]=positive, cmp_o[1]=zero.
- R8: Opcodes 31/10, 31/138, 31/234, 31/202, 12 and 13 load the carry flag with the unsigned carry out of the top bit. Opcodes 31/266, 14 and 15 leave it unchanged.
- R9: Opcode 13 always updates `cmp_o`. For all immediate forms, the overflow-enable and record input bits are ignored.
- R10: The sticky flag stays set until reset or `sum_ovf_clr_i`. If a clear and an overflowing instruction arrive in the same cycle, the flag ends set.
- R11: `cmp_o[0]` equals the sticky flag value after the current instruction's overflow update.
- R12: When `in_valid_i` is low, or the opcode pair is not one listed above, no write enable rises and the carry and overflow flags keep their values.
- R13: Results, enables and flags appear on the outputs one clock after the request. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | Instruction present this cycle |
| opc_i | input | 6 | Primary opcode field |
| xop_i | input | 9 | Extended opcode field |
| ovf_en_i | input | 1 | Overflow-enable instruction bit |
| rec_i | input | 1 | Record instruction bit |
| src_a_idx_i | input | 5 | Index of the first source register |
| src_a_i | input | 32 | Contents of the first source register |
| src_b_i | input | 32 | Contents of the second source register |
| imm_i | input | 16 | Immediate field |
| sum_ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| result_o | output | 32 | Sum |
| rd_we_o | output | 1 | Destination write enable |
| cmp_o | output | 4 | Comparison field {neg, pos, zero, sticky} |
| cmp_we_o | output | 1 | Comparison field write enable |
| carry_o | output | 1 | Carry flag |
| ovf_o | output | 1 | Overflow flag |
| sum_ovf_o | output | 1 | Sticky summary-overflow flag |

## Verification
A corrupted carry flag stays hidden until the next carry-in form. That instruction then returns a sum that is off by one, so the bench follows every carry-setting operation with such a form. A wrongly held sticky flag shows on `sum_ovf_o` one cycle later, and on `cmp_o[0]` at the next recorded instruction. The bench therefore checks the flag both directly and through a later recorded instruction. A wrong overflow or carry update shows on the flag ports one cycle after the instruction.

// File: rtl/int_add_pkg.sv
// Package: opcode values and operation kinds shared by the add unit.
package int_add_pkg;
    localparam logic [5:0] OPC_EXT    = 6'd31;
    localparam logic [5:0] OPC_ADDI   = 6'd14;
    localparam logic [5:0] OPC_ADDIC  = 6'd12;
    localparam logic [5:0] OPC_ADDICR = 6'd13;
    localparam logic [5:0] OPC_ADDIS  = 6'd15;
    localparam logic [8:0] XOP_ADD    = 9'd266;
    localparam logic [8:0] XOP_ADDC   = 9'd10;
    localparam logic [8:0] XOP_ADDE   = 9'd138;
    localparam logic [8:0] XOP_ADDME  = 9'd234;
    localparam logic [8:0] XOP_ADDZE  = 9'd202;

    typedef enum logic [3:0] {
        K_NONE, K_ADD, K_ADDC, K_ADDE, K_ADDME, K_ADDZE,
        K_ADDI, K_ADDIC, K_ADDICR, K_ADDIS
    } add_kind_e;
endpackage

// File: rtl/int_add_decode.sv
// Decoder: maps opcode fields to an operation kind and its side effects.
// Assumes the caller gives the raw instruction bit fields.
module int_add_decode
    import int_add_pkg::*;
(
    input  logic [5:0] opc_i,
    input  logic [8:0] xop_i,
    input  logic       ovf_en_i,
    input  logic       rec_i,
    output logic       legal_o,
    output add_kind_e  kind_o,
    output logic       ovf_upd_o,
    output logic       cmp_upd_o,
    output logic       carry_upd_o
);
    // Select the kind and which flags it writes.
    always_comb begin
        legal_o     = 1'b0;
        kind_o      = K_NONE;
        ovf_upd_o   = 1'b0;
        cmp_upd_o   = 1'b0;
        carry_upd_o = 1'b0;
        case (opc_i)
            OPC_EXT: begin
                ovf_upd_o = ovf_en_i;
                cmp_upd_o = rec_i;
                legal_o   = 1'b1;
                case (xop_i)
                    XOP_ADD:   kind_o = K_ADD;
                    XOP_ADDC:  begin kind_o = K_ADDC;  carry_upd_o = 1'b1; end
                    XOP_ADDE:  begin kind_o = K_ADDE;  carry_upd_o = 1'b1; end
                    XOP_ADDME: begin kind_o = K_ADDME; carry_upd_o = 1'b1; end
                    XOP_ADDZE: begin kind_o = K_ADDZE; carry_upd_o = 1'b1; end
                    default: begin
                        legal_o   = 1'b0;
                        ovf_upd_o = 1'b0;
                        cmp_upd_o = 1'b0;
                    end
                endcase
            end
            OPC_ADDI:   begin legal_o = 1'b1; kind_o = K_ADDI; end
            OPC_ADDIS:  begin legal_o = 1'b1; kind_o = K_ADDIS; end
            OPC_ADDIC:  begin legal_o = 1'b1; kind_o = K_ADDIC; carry_upd_o = 1'b1; end
            OPC_ADDICR: begin
                legal_o     = 1'b1;
                kind_o      = K_ADDICR;
                carry_upd_o = 1'b1;
                cmp_upd_o   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/int_add_operands.sv
// Operand selector: builds both addends and the carry-in for each kind.
// Assumes W >= IMM_W; a zero index selects constant 0 only for the
// plain and shifted immediate forms.
module int_add_operands
    import int_add_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16,
    parameter int IDX_W = 5
) (
    input  add_kind_e        kind_i,
    input  logic [IDX_W-1:0] a_idx_i,
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             carry_i,
    output logic [W-1:0]     op_a_o,
    output logic [W-1:0]     op_b_o,
    output logic             cin_o
);
    localparam int EXT_W = W - IMM_W;

    logic [W-1:0] imm_sx;
    logic [W-1:0] imm_hi;
    logic [W-1:0] a_or_zero;

    // Sign-extend the immediate and form its shifted variant.
    always_comb begin
        imm_sx    = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        imm_hi    = imm_sx << IMM_W;
        a_or_zero = (a_idx_i == '0) ? '0 : a_i;
    end

    // Pick addends and carry-in per kind.
    always_comb begin
        op_a_o = a_i;
        op_b_o = b_i;
        cin_o  = 1'b0;
        case (kind_i)
            K_ADDE:   cin_o = carry_i;
            K_ADDME:  begin op_b_o = '1; cin_o = carry_i; end
            K_ADDZE:  begin op_b_o = '0; cin_o = carry_i; end
            K_ADDI:   begin op_a_o = a_or_zero; op_b_o = imm_sx; end
            K_ADDIS:  begin op_a_o = a_or_zero; op_b_o = imm_hi; end
            K_ADDIC,
            K_ADDICR: op_b_o = imm_sx;
            default: ;
        endcase
    end
endmodule

// File: rtl/int_add_core.sv
// Adder core: W-bit sum with carry-in, unsigned carry-out, signed overflow.
module int_add_core #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    // One wide addition, then overflow from operand and result signs.
    always_comb begin
        {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        ovf_o = (a_i[W-1] == b_i[W-1]) && (sum_o[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/int_add_unit.sv
// Integer add unit: decodes the add family, computes the sum and keeps
// carry, overflow, sticky overflow and the comparison field.
// Assumes register file access happens outside; outputs lag by one clock.
module int_add_unit
    import int_add_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid_i,
    input  logic [5:0]       opc_i,
    input  logic [8:0]       xop_i,
    input  logic             ovf_en_i,
    input  logic             rec_i,
    input  logic [IDX_W-1:0] src_a_idx_i,
    input  logic [W-1:0]     src_a_i,
    input  logic [W-1:0]     src_b_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             sum_ovf_clr_i,
    output logic [W-1:0]     result_o,
    output logic             rd_we_o,
    output logic [3:0]       cmp_o,
    output logic             cmp_we_o,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             sum_ovf_o
);
    logic      legal, ovf_upd, cmp_upd, carry_upd;
    add_kind_e kind;
    logic [W-1:0] op_a, op_b, sum;
    logic      cin, cout, ovf_raw;
    logic      fire, ovf_set, so_next;
    logic [3:0] cmp_next;

    int_add_decode u_dec (
        .opc_i(opc_i), .xop_i(xop_i), .ovf_en_i(ovf_en_i), .rec_i(rec_i),
        .legal_o(legal), .kind_o(kind), .ovf_upd_o(ovf_upd),
        .cmp_upd_o(cmp_upd), .carry_upd_o(carry_upd)
    );

    int_add_operands #(.W(W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_ops (
        .kind_i(kind), .a_idx_i(src_a_idx_i), .a_i(src_a_i), .b_i(src_b_i),
        .imm_i(imm_i), .carry_i(carry_o), .op_a_o(op_a), .op_b_o(op_b),
        .cin_o(cin)
    );

    int_add_core #(.W(W)) u_core (
        .a_i(op_a), .b_i(op_b), .cin_i(cin),
        .sum_o(sum), .cout_o(cout), .ovf_o(ovf_raw)
    );

    // Next sticky flag and comparison field; set wins over clear.
    always_comb begin
        fire     = in_valid_i && legal;
        ovf_set  = fire && ovf_upd && ovf_raw;
        so_next  = (sum_ovf_clr_i ? 1'b0 : sum_ovf_o) | ovf_set;
        cmp_next = {sum[W-1], !sum[W-1] && (sum != '0), sum == '0, so_next};
    end

    // Register result, enables and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o  <= '0;
            rd_we_o   <= 1'b0;
            cmp_o     <= '0;
            cmp_we_o  <= 1'b0;
            carry_o   <= 1'b0;
            ovf_o     <= 1'b0;
            sum_ovf_o <= 1'b0;
        end else begin
            rd_we_o   <= fire;
            cmp_we_o  <= fire && cmp_upd;
            sum_ovf_o <= so_next;
            if (fire) result_o <= sum;
            if (fire && carry_upd) carry_o <= cout;
            if (fire && ovf_upd) ovf_o <= ovf_raw;
            if (fire && cmp_upd) cmp_o <= cmp_next;
        end
    end
endmodule

// File: rtl/int_add_unit_chk.sv
// Checker: port-level properties of the add unit, bound to every instance.
module int_add_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid_i,
    input logic         sum_ovf_clr_i,
    input logic [W-1:0] result_o,
    input logic         rd_we_o,
    input logic [3:0]   cmp_o,
    input logic         cmp_we_o,
    input logic         carry_o,
    input logic         ovf_o,
    input logic         sum_ovf_o
);
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_ovf_o && !sum_ovf_clr_i) |=> sum_ovf_o); // R10
    AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> ($stable(carry_o) && $stable(ovf_o) && !rd_we_o)); // R12
    AST_CMP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we_o |-> (cmp_o[0] == sum_ovf_o)); // R11
    AST_CMP_ONE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we_o |-> ($countones(cmp_o[3:1]) == 1)); // R7
    AST_CMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we_o |-> (cmp_o[1] == (result_o == '0))); // R7
    AST_CMP_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we_o |-> rd_we_o); // R9
    AST_OVF_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> sum_ovf_o); // R6
endmodule

bind int_add_unit int_add_unit_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i),
    .sum_ovf_clr_i(sum_ovf_clr_i), .result_o(result_o), .rd_we_o(rd_we_o),
    .cmp_o(cmp_o), .cmp_we_o(cmp_we_o), .carry_o(carry_o), .ovf_o(ovf_o),
    .sum_ovf_o(sum_ovf_o)
);

// File: tb/int_add_unit_tb_top.sv
`timescale 1ns/1ps
// Bench: vector table walk with a reference flag model, then directed tests.
module int_add_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  opc = '0;
    logic [8:0]  xop = '0;
    logic        oe = 1'b0, rc = 1'b0, clr = 1'b0;
    logic [4:0]  idx = '0;
    logic [31:0] a = '0, b = '0;
    logic [15:0] imm = '0;
    logic [31:0] result;
    logic        rd_we, cmp_we, carry, ovf, sovf;
    logic [3:0]  cmp;

    int checks = 0;
    int errors = 0;

    // Reference state
    logic        m_ca = 0, m_ov = 0, m_so = 0, m_rdwe = 0, m_cmpwe = 0;
    logic [3:0]  m_cmp = 0;

    always #2.5 clk = ~clk;

    int_add_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .opc_i(opc),
        .xop_i(xop), .ovf_en_i(oe), .rec_i(rc), .src_a_idx_i(idx),
        .src_a_i(a), .src_b_i(b), .imm_i(imm), .sum_ovf_clr_i(clr),
        .result_o(result), .rd_we_o(rd_we), .cmp_o(cmp), .cmp_we_o(cmp_we),
        .carry_o(carry), .ovf_o(ovf), .sum_ovf_o(sovf)
    );

    typedef struct packed {
        logic [5:0]  opc;
        logic [8:0]  xop;
        logic        oe;
        logic        rc;
        logic [4:0]  idx;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] imm;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{6'd31, 9'd266, 1'b0, 1'b1, 5'd1, 32'd5,        32'd7,        16'h0,    32'd12},        // R1 add
        '{6'd31, 9'd10,  1'b0, 1'b1, 5'd1, 32'hFFFFFFFF, 32'd1,        16'h0,    32'd0},         // R8 carry out
        '{6'd31, 9'd138, 1'b0, 1'b0, 5'd1, 32'd10,       32'd20,       16'h0,    32'd31},        // R3 carry in
        '{6'd31, 9'd234, 1'b0, 1'b1, 5'd1, 32'd0,        32'd55,       16'h0,    32'hFFFFFFFF},  // R3 minus one
        '{6'd31, 9'd10,  1'b1, 1'b1, 5'd1, 32'h80000000, 32'h80000000, 16'h0,    32'd0},         // R6 overflow
        '{6'd31, 9'd202, 1'b0, 1'b0, 5'd1, 32'd7,        32'd99,       16'h0,    32'd8},         // R3 plus carry
        '{6'd14, 9'd0,   1'b0, 1'b0, 5'd0, 32'd12345,    32'd0,        16'hFFFF, 32'hFFFFFFFF},  // R4 zero index
        '{6'd14, 9'd0,   1'b0, 1'b0, 5'd3, 32'd100,      32'd0,        16'h0010, 32'd116},       // R5 sign ext
        '{6'd15, 9'd0,   1'b0, 1'b0, 5'd0, 32'd99,       32'd0,        16'h8000, 32'h80000000},  // R4 shifted
        '{6'd15, 9'd0,   1'b0, 1'b0, 5'd4, 32'd1,        32'd0,        16'h0001, 32'h00010001},  // R5 shifted
        '{6'd12, 9'd0,   1'b0, 1'b0, 5'd0, 32'd5,        32'd0,        16'hFFFF, 32'd4},         // R4 index ignored
        '{6'd13, 9'd0,   1'b0, 1'b0, 5'd2, 32'hFFFFFFFE, 32'd0,        16'h0001, 32'hFFFFFFFF},  // R9 record
        '{6'd31, 9'd266, 1'b1, 1'b1, 5'd1, 32'h7FFFFFFF, 32'd1,        16'h0,    32'h80000000},  // R6 overflow
        '{6'd31, 9'd266, 1'b1, 1'b0, 5'd1, 32'd1,        32'd1,        16'h0,    32'd2},         // R10 sticky
        '{6'd31, 9'd234, 1'b0, 1'b0, 5'd1, 32'd1,        32'd0,        16'h0,    32'd0},         // R3 minus one
        '{6'd31, 9'd138, 1'b0, 1'b1, 5'd1, 32'hFFFFFFFF, 32'd0,        16'h0,    32'd0},         // R3 carry in
        '{6'd14, 9'd0,   1'b1, 1'b1, 5'd1, 32'h7FFFFFFF, 32'd0,        16'h0001, 32'h80000000}   // R9 bits ignored
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference model of one clock: computes flag and enable expectations.
    task automatic model(input logic v, input logic [5:0] o, input logic [8:0] x,
                         input logic e, input logic r, input logic [31:0] ra,
                         input logic [31:0] rb, input logic [15:0] im,
                         input logic [4:0] ix, input logic c);
        logic [32:0] s;
        logic [31:0] opa, opb, sx;
        logic ci, leg, ovu, cmu, cau, ov;
        sx = {{16{im[15]}}, im};
        opa = ra; opb = rb; ci = 0; leg = 1; ovu = 0; cmu = 0; cau = 0;
        if (o == 6'd31) begin
            ovu = e; cmu = r;
            case (x)
                9'd266: ;
                9'd10:  cau = 1;
                9'd138: begin cau = 1; ci = m_ca; end
                9'd234: begin cau = 1; ci = m_ca; opb = 32'hFFFFFFFF; end
                9'd202: begin cau = 1; ci = m_ca; opb = 0; end
                default: leg = 0;
            endcase
        end else if (o == 6'd14) begin opa = (ix == 0) ? 0 : ra; opb = sx; end
        else if (o == 6'd15) begin opa = (ix == 0) ? 0 : ra; opb = {im, 16'h0}; end
        else if (o == 6'd12) begin opb = sx; cau = 1; end
        else if (o == 6'd13) begin opb = sx; cau = 1; cmu = 1; end
        else leg = 0;
        leg = leg && v;
        s = {1'b0, opa} + {1'b0, opb} + {32'd0, ci};
        ov = (opa[31] == opb[31]) && (s[31] != opa[31]);
        m_so = (c ? 1'b0 : m_so) | (leg && ovu && ov);
        m_rdwe = leg;
        m_cmpwe = leg && cmu;
        if (leg && cau) m_ca = s[32];
        if (leg && ovu) m_ov = ov;
        if (leg && cmu) m_cmp = {s[31], !s[31] && (s[31:0] != 0), s[31:0] == 0, m_so};
    endtask

    // Apply one request at a falling edge and check at the next one.
    task automatic step(input logic v, input logic [5:0] o, input logic [8:0] x,
                        input logic e, input logic r, input logic [4:0] ix,
                        input logic [31:0] ra, input logic [31:0] rb,
                        input logic [15:0] im, input logic c, input string req);
        in_valid = v; opc = o; xop = x; oe = e; rc = r; idx = ix;
        a = ra; b = rb; imm = im; clr = c;
        model(v, o, x, e, r, ra, rb, im, ix, c);
        @(negedge clk);
        in_valid = 0; clr = 0;
        check(req, "rd_we", {31'd0, rd_we}, {31'd0, m_rdwe});
        check(req, "cmp_we", {31'd0, cmp_we}, {31'd0, m_cmpwe});
        check("R8", "carry", {31'd0, carry}, {31'd0, m_ca});
        check("R6", "ovf", {31'd0, ovf}, {31'd0, m_ov});
        check("R10", "sum_ovf", {31'd0, sovf}, {31'd0, m_so});
        check("R7", "cmp", {28'd0, cmp}, {28'd0, m_cmp});
    endtask

    task automatic check_reset_state();
        check("R13", "reset result", result, 32'd0);
        check("R13", "reset flags", {25'd0, rd_we, cmp_we, carry, ovf, sovf, 2'b0},
              32'd0);
        check("R13", "reset cmp", {28'd0, cmp}, 32'd0);
    endtask

    initial begin
        #100us;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state(); // R13
        rst_n = 1;
        @(negedge clk);

        foreach (VEC[i]) begin
            step(1'b1, VEC[i].opc, VEC[i].xop, VEC[i].oe, VEC[i].rc, VEC[i].idx,
                 VEC[i].a, VEC[i].b, VEC[i].imm, 1'b0, "R1");
            check($sformatf("R2 vec%0d", i), "result", result, VEC[i].exp);
        end

        // R12: unknown extended opcode and idle cycle
        step(1'b1, 6'd31, 9'd100, 1'b1, 1'b1, 5'd1, 32'h7FFFFFFF, 32'd1, 16'h0,
             1'b0, "R12");
        step(1'b0, 6'd31, 9'd266, 1'b1, 1'b1, 5'd1, 32'h7FFFFFFF, 32'd1, 16'h0,
             1'b0, "R12");
        check("R12", "result held", result, 32'h80000000);

        // R10: clear alone, then clear together with an overflow
        step(1'b0, 6'd0, 9'd0, 1'b0, 1'b0, 5'd0, 32'd0, 32'd0, 16'h0, 1'b1, "R10");
        check("R10", "cleared", {31'd0, sovf}, 32'd0);
        step(1'b1, 6'd31, 9'd266, 1'b1, 1'b1, 5'd1, 32'h80000000, 32'hFFFFFFFF,
             16'h0, 1'b1, "R10");
        check("R10", "set beats clear", {31'd0, sovf}, 32'd1);
        check("R11", "cmp sticky bit", {31'd0, cmp[0]}, 32'd1);
        check("R7", "positive result", {28'd0, cmp}, 32'h5);

        // R11: record with clear on a clean add shows the updated sticky bit
        step(1'b1, 6'd31, 9'd266, 1'b0, 1'b1, 5'd1, 32'd0, 32'd0, 16'h0, 1'b1, "R11");
        check("R11", "cmp after clear", {28'd0, cmp}, 32'h2);

        // R13: reset mid-run
        in_valid = 1; opc = 6'd14; idx = 5'd1; a = 32'd9; imm = 16'h1;
        rst_n = 0;
        @(negedge clk);
        in_valid = 0;
        check_reset_state();
        rst_n = 1;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule